// File: doc/BRIEF.md
# Conditional Branch Resolver

This block resolves conditional branches in a single-issue integer pipeline. It works as pure combinational logic on one decoded instruction. It reads the primary opcode, the rs and rt instruction fields, both register operands, the current program counter, the raw 16-bit branch offset and one external condition flag. From these it reports four things: whether the instruction is a conditional branch, whether that branch is taken, the branch destination, and whether the instruction in the delay slot must be squashed.

Two opcode spaces carry branches. Branches in the primary opcode space compare rs with rt or with zero. The register-immediate group uses the rt field as a sub-opcode. Its compare-with-zero branches can also write a return address into the link register. The coprocessor groups branch on the external condition flag. Each family has a "likely" form. When a likely branch falls through, the pipeline discards the delay-slot instruction, and the block tells it to through `annul_o`. Fetch redirection and delay-slot sequencing stay with the surrounding pipeline.

Top module: `branch_resolver`

## Requirements
- R1: With opcode 1, rt field 0 is taken when rs is negative and rt field 1 is taken when rs is zero or positive. rs is read as two's complement.
- R2: With opcode 1, rt fields 2 and 3 use the same conditions as 0 and 1. They are the likely forms.
- R3: With opcode 1, rt fields 16, 17, 18 and 19 match fields 0 to 3 and also link. `link_we_o` is 1 whether or not the branch is taken, `link_addr_o` is pc+8, and `link_reg_o` is 31.
- R4: Opcode 4 is taken when rs equals rt. Opcode 5 is taken when they differ.
- R5: Opcode 6 is taken when signed rs is zero or negative. Opcode 7 is taken when signed rs is strictly positive.
- R6: Opcodes 20 to 23 use the conditions of opcodes 4 to 7. They are the likely forms.
- R7: Opcodes 17 and 18 with rs field 8 are coprocessor branches. rt field bit 0 selects the flag value that branches (0 branches when `cond_flag_i` is 0, 1 branches when it is 1). rt field bit 1 selects the likely form.
- R8: `target_o` equals pc + 4 + (offset sign-extended, times 4), modulo 2^32.
- R9: `annul_o` is 1 exactly when the instruction is a likely branch that is not taken.
- R10: Any other encoding, including an opcode 1 rt field outside the eight listed and a coprocessor opcode with an rs field other than 8, drives `is_branch_o`, `taken_o`, `link_we_o` and `annul_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode field |
| rs_fld_i | input | 5 | rs instruction field (coprocessor sub-opcode) |
| rt_fld_i | input | 5 | rt instruction field (sub-opcode / flag select) |
| rs_val_i | input | 32 | rs register operand |
| rt_val_i | input | 32 | rt register operand |
| pc_i | input | 32 | Address of the branch instruction |
| offset_i | input | 16 | Raw branch offset in words |
| cond_flag_i | input | 1 | External coprocessor condition flag |
| is_branch_o | output | 1 | Encoding is a conditional branch |
| taken_o | output | 1 | Branch condition holds |
| target_o | output | 32 | Branch destination |
| link_we_o | output | 1 | Write return address to link register |
| link_reg_o | output | 5 | Link register index |
| link_addr_o | output | 32 | Return address |
| annul_o | output | 1 | Squash the delay-slot instruction |

## Verification
In one evaluation, a linking likely branch on opcode 1 can raise the link write and the annul request together. This happens when it falls through: rt field 18 or 19 with an rs that fails the condition. The sweep produces this case by crossing every rt field with operands of both signs, including the most negative and most positive values. For each vector it checks that the link write stays at 1 and the return address at pc+8, and that annul equals the inverse of taken. A separate sweep runs both coprocessor opcodes against both flag values and both rs fields (8 and not 8). It checks that the flag alone decides the outcome and that a wrong rs field produces no branch.

// File: rtl/branch_resolver_pkg.sv
package branch_resolver_pkg;

  localparam logic [5:0] OP_REGIMM = 6'h01;
  localparam logic [5:0] OP_COP1   = 6'h11;
  localparam logic [5:0] OP_COP2   = 6'h12;
  localparam logic [4:0] RS_CC_BR  = 5'h08;

  typedef enum logic [3:0] {
    CND_NONE,
    CND_EQ,
    CND_NE,
    CND_LEZ,
    CND_GTZ,
    CND_LTZ,
    CND_GEZ,
    CND_FLAG_F,
    CND_FLAG_T
  } cnd_e;

  typedef struct packed {
    cnd_e cnd;
    logic likely;
    logic link;
  } br_ctl_t;

endpackage

// File: rtl/br_class.sv
module br_class
  import branch_resolver_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [4:0] rs_fld_i,
  input  logic [4:0] rt_fld_i,
  output br_ctl_t    ctl_o
);

  function automatic cnd_e pick_primary(input logic [1:0] sel);
    case (sel)
      2'd0:    return CND_EQ;
      2'd1:    return CND_NE;
      2'd2:    return CND_LEZ;
      default: return CND_GTZ;
    endcase
  endfunction

  always_comb begin
    ctl_o.cnd    = CND_NONE;
    ctl_o.likely = 1'b0;
    ctl_o.link   = 1'b0;
    if (opcode_i == OP_REGIMM) begin
      // rt[4]=link, rt[1]=likely, rt[0]=ge-zero; rt[3:2] must be clear
      if (rt_fld_i[3:2] == 2'b00) begin
        ctl_o.cnd    = rt_fld_i[0] ? CND_GEZ : CND_LTZ;
        ctl_o.likely = rt_fld_i[1];
        ctl_o.link   = rt_fld_i[4];
      end
    end else if ((opcode_i[5:2] == 4'b0001) || (opcode_i[5:2] == 4'b0101)) begin
      ctl_o.cnd    = pick_primary(opcode_i[1:0]);
      ctl_o.likely = opcode_i[4];
    end else if (((opcode_i == OP_COP1) || (opcode_i == OP_COP2)) &&
                 (rs_fld_i == RS_CC_BR)) begin
      ctl_o.cnd    = rt_fld_i[0] ? CND_FLAG_T : CND_FLAG_F;
      ctl_o.likely = rt_fld_i[1];
    end
  end

endmodule

// File: rtl/br_eval.sv
module br_eval
  import branch_resolver_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cnd_e            cnd_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  input  logic            cond_flag_i,
  output logic            taken_o
);

  logic rs_neg, rs_zero, ops_eq;

  assign rs_neg  = rs_val_i[XLEN-1];
  assign rs_zero = (rs_val_i == '0);
  assign ops_eq  = (rs_val_i == rt_val_i);

  always_comb begin
    case (cnd_i)
      CND_EQ:     taken_o = ops_eq;
      CND_NE:     taken_o = !ops_eq;
      CND_LEZ:    taken_o = rs_neg || rs_zero;
      CND_GTZ:    taken_o = !rs_neg && !rs_zero;
      CND_LTZ:    taken_o = rs_neg;
      CND_GEZ:    taken_o = !rs_neg;
      CND_FLAG_F: taken_o = !cond_flag_i;
      CND_FLAG_T: taken_o = cond_flag_i;
      default:    taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/br_addr.sv
module br_addr #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned OFFW = 16
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [OFFW-1:0] offset_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_addr_o
);

  localparam int unsigned EXTW = XLEN - OFFW - 2;

  logic [XLEN-1:0] disp, seq_pc;

  assign disp        = {{EXTW{offset_i[OFFW-1]}}, offset_i, 2'b00};
  assign seq_pc      = pc_i + XLEN'(4);
  assign target_o    = seq_pc + disp;
  assign link_addr_o = pc_i + XLEN'(8);

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import branch_resolver_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned OFFW     = 16,
  parameter int unsigned RIDX_W   = 5,
  parameter int unsigned LINK_REG = 31
) (
  input  logic [5:0]        opcode_i,
  input  logic [4:0]        rs_fld_i,
  input  logic [4:0]        rt_fld_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [OFFW-1:0]   offset_i,
  input  logic              cond_flag_i,
  output logic              is_branch_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   target_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_reg_o,
  output logic [XLEN-1:0]   link_addr_o,
  output logic              annul_o
);

  br_ctl_t ctl;
  logic    cond_hit;

  br_class u_class (
    .opcode_i (opcode_i),
    .rs_fld_i (rs_fld_i),
    .rt_fld_i (rt_fld_i),
    .ctl_o    (ctl)
  );

  br_eval #(.XLEN(XLEN)) u_eval (
    .cnd_i       (ctl.cnd),
    .rs_val_i    (rs_val_i),
    .rt_val_i    (rt_val_i),
    .cond_flag_i (cond_flag_i),
    .taken_o     (cond_hit)
  );

  br_addr #(.XLEN(XLEN), .OFFW(OFFW)) u_addr (
    .pc_i        (pc_i),
    .offset_i    (offset_i),
    .target_o    (target_o),
    .link_addr_o (link_addr_o)
  );

  assign is_branch_o = (ctl.cnd != CND_NONE);
  assign taken_o     = is_branch_o && cond_hit;
  assign link_we_o   = is_branch_o && ctl.link;
  assign annul_o     = is_branch_o && ctl.likely && !cond_hit;
  assign link_reg_o  = RIDX_W'(LINK_REG);

endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned OFFW = 16
) (
  input logic [5:0]      opcode_i,
  input logic [4:0]      rs_fld_i,
  input logic [4:0]      rt_fld_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic [XLEN-1:0] pc_i,
  input logic            cond_flag_i,
  input logic            is_branch_o,
  input logic            taken_o,
  input logic [XLEN-1:0] target_o,
  input logic            link_we_o,
  input logic            annul_o
);

  always_comb begin
    p_annul_fallthru_r9: assert (!annul_o || (is_branch_o && !taken_o));
    p_idle_quiet_r10: assert (is_branch_o || (!taken_o && !link_we_o && !annul_o));
    p_link_regimm_r3: assert (!link_we_o || (opcode_i == 6'h01 && rt_fld_i[4]));
    p_eq_operands_r4: assert (opcode_i != 6'h04 || (taken_o == (rs_val_i == rt_val_i)));
    p_tgt_align_r8: assert (target_o[1:0] == pc_i[1:0]);
    p_flag_follow_r7: assert (!((opcode_i == 6'h11 || opcode_i == 6'h12) && rs_fld_i == 5'h08)
                              || (taken_o == (cond_flag_i == rt_fld_i[0])));
  end

endmodule

bind branch_resolver branch_resolver_chk #(.XLEN(XLEN), .OFFW(OFFW)) u_chk (
  .opcode_i    (opcode_i),
  .rs_fld_i    (rs_fld_i),
  .rt_fld_i    (rt_fld_i),
  .rs_val_i    (rs_val_i),
  .rt_val_i    (rt_val_i),
  .pc_i        (pc_i),
  .cond_flag_i (cond_flag_i),
  .is_branch_o (is_branch_o),
  .taken_o     (taken_o),
  .target_o    (target_o),
  .link_we_o   (link_we_o),
  .annul_o     (annul_o)
);

// File: tb/tb_branch_resolver.sv
module tb_branch_resolver;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  opcode;
  logic [4:0]  rs_fld, rt_fld;
  logic [31:0] rs_val, rt_val, pc;
  logic [15:0] offset;
  logic        cflag;
  logic        is_br, taken, link_we, annul;
  logic [31:0] target, link_addr;
  logic [4:0]  link_reg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  branch_resolver dut (
    .opcode_i    (opcode),
    .rs_fld_i    (rs_fld),
    .rt_fld_i    (rt_fld),
    .rs_val_i    (rs_val),
    .rt_val_i    (rt_val),
    .pc_i        (pc),
    .offset_i    (offset),
    .cond_flag_i (cflag),
    .is_branch_o (is_br),
    .taken_o     (taken),
    .target_o    (target),
    .link_we_o   (link_we),
    .link_reg_o  (link_reg),
    .link_addr_o (link_addr),
    .annul_o     (annul)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0h rs_f=%0h rt_f=%0h rs=%h rt=%h flag=%0b act=%h exp=%h",
               tag, what, opcode, rs_fld, rt_fld, rs_val, rt_val, cflag, act, exp);
    end
  endtask

  task automatic apply_and_check();
    logic signed [31:0] s;
    logic eb, et, el, ely;
    logic [31:0] etgt;
    string tag;
    s = rs_val; eb = 0; et = 0; el = 0; ely = 0; tag = "R10";
    if (opcode == 6'd1) begin
      if (rt_fld inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd16, 5'd17, 5'd18, 5'd19}) begin
        eb = 1;
        et = rt_fld[0] ? (s >= 0) : (s < 0);
        ely = rt_fld[1];
        el = (rt_fld >= 5'd16);
        tag = el ? "R3" : (ely ? "R2" : "R1");
      end
    end else if ((opcode >= 6'd4 && opcode <= 6'd7) || (opcode >= 6'd20 && opcode <= 6'd23)) begin
      eb = 1;
      ely = (opcode >= 6'd20);
      case (opcode % 4)
        0: et = (rs_val == rt_val);
        1: et = (rs_val != rt_val);
        2: et = (s <= 0);
        default: et = (s > 0);
      endcase
      tag = ely ? "R6" : ((opcode % 4 < 2) ? "R4" : "R5");
    end else if ((opcode == 6'd17 || opcode == 6'd18) && rs_fld == 5'd8) begin
      eb = 1;
      et = (cflag == rt_fld[0]);
      ely = rt_fld[1];
      tag = "R7";
    end
    etgt = pc + 32'd4 + 32'($signed(offset)) * 32'd4;
    #1;
    chk(tag, "is_branch", 32'(is_br), 32'(eb));
    chk(tag, "taken", 32'(taken), 32'(et));
    chk(tag, "link_we", 32'(link_we), 32'(el));
    chk("R9", "annul", 32'(annul), 32'(eb && ely && !et));
    chk("R8", "target", target, etgt);
    if (el) begin
      chk("R3", "link_addr", link_addr, pc + 32'd8);
      chk("R3", "link_reg", 32'(link_reg), 32'd31);
    end
  endtask

  initial begin
    logic [31:0] vals [5];
    logic [31:0] pcs [3];
    logic [15:0] offs [5];
    vals = '{32'h0, 32'h1, 32'hffff_ffff, 32'h7fff_ffff, 32'h8000_0000};
    pcs  = '{32'h0040_0000, 32'hffff_fffc, 32'h0000_0100};
    offs = '{16'h0000, 16'h7fff, 16'h8000, 16'hffff, 16'h0001};
    opcode = '0; rs_fld = '0; rt_fld = '0; rs_val = '0; rt_val = '0;
    pc = '0; offset = '0; cflag = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R10: all-zero instruction word is not a branch
    #1;
    chk("R10", "reset is_branch", 32'(is_br), 32'd0);
    chk("R10", "reset taken", 32'(taken), 32'd0);
    chk("R9", "reset annul", 32'(annul), 32'd0);
    for (int op = 0; op < 64; op++) begin
      for (int rt = 0; rt < 32; rt++) begin
        for (int rf = 0; rf < 2; rf++) begin
          for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < 5; a++) begin
              for (int b = 0; b < 5; b++) begin
                opcode = 6'(op); rt_fld = 5'(rt);
                rs_fld = rf ? 5'd8 : 5'(rt ^ 5);
                cflag = f[0];
                rs_val = vals[a]; rt_val = vals[b];
                pc = pcs[(a + b) % 3];
                offset = offs[(op + rt) % 5];
                apply_and_check();
              end
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule